// File: doc/BRIEF.md
# Scroll Address Register Pair

This block holds the two 15-bit video memory addresses of a tile-based picture generator. The current address (`vaddr`) drives fetches. The temporary address (`taddr`) is staged by the processor and later copied into the current address, either in full or in parts. The processor reaches the block through four register selects: a scroll register, a two-write address register, a status read and a data port. The scroll and address registers share one first/second write toggle.

A render-timing input gives the dot, the scanline and the two display enables. From these the block steps the coarse horizontal and vertical fields while the picture is being drawn. It also reloads the horizontal and vertical fields from the temporary address at fixed dots.

Some processor writes land on the same dot as a hardware step. For these the block models the bus conflict: the affected bits of both addresses take the bitwise AND of the written value and the stepped value. All updates become visible on the outputs one clock after the cycle in which they are requested. Each clock is one dot.

Top module: `scroll_addr_pair`

## Requirements
- R1: After `rst_n` is released, `vaddr`, `taddr`, `fine_x` and `write_toggle` are all zero.
- R2: A scroll write (`cpu_wr`, `cpu_sel`=0) with toggle 0 loads `taddr[4:0]` from data bits 7:3 and `fine_x` from data bits 2:0. With toggle 1 it loads `taddr[14:12]` from data bits 2:0 and `taddr[9:5]` from data bits 7:3. All other bits keep their values, and the toggle inverts.
- R3: An address write (`cpu_sel`=1) with toggle 0 loads `taddr[13:8]` from data bits 5:0 and clears `taddr[14]`. With toggle 1 it loads `taddr[7:0]` and copies the whole new `taddr` into `vaddr` in the same update, even while rendering. The toggle it inverts is the one shared with R2.
- R4: A status read (`cpu_rd`, `cpu_sel`=2) clears the toggle and leaves both addresses unchanged.
- R5: A data-port access (`cpu_sel`=3, read or write) outside rendering adds 32 to `vaddr` when `inc_row` is 1, and adds 1 otherwise.
- R6: A data-port access during rendering applies a coarse X step and then a Y step to `vaddr`, on top of any hardware step of that dot.
- R7: A coarse X step increments `vaddr[4:0]`. From 31 it wraps to 0 and inverts `vaddr[10]`. While rendering, the hardware applies it on every dot that is a multiple of 8 from 8 to 256, and on dots 328 and 336.
- R8: While rendering, dot 256 applies a Y step after its coarse X step. Fine Y `vaddr[14:12]` increments. From 7 it wraps to 0 and advances coarse Y `vaddr[9:5]`. Coarse Y 29 wraps to 0 and inverts `vaddr[11]`. Coarse Y 31 wraps to 0 without inverting it.
- R9: While rendering, dot 257 copies `taddr` bits 10 and 4:0 into `vaddr`.
- R10: While rendering on the pre-render line (261), dots 280 to 304 copy `taddr` bits 14:11 and 9:5 into `vaddr`. This happens on no other line.
- R11: Rendering means `bg_en` or `spr_en` is 1 and `line` is at most 239 or equals 261. Outside rendering, dots make no change to `vaddr`.
- R12: A second address write on dot 256 while rendering sets all 15 bits of both `vaddr` and `taddr` to the AND of the new `taddr` and the stepped `vaddr`.
- R13: A second address write on any other coarse X step dot while rendering sets bits 10 and 4:0 of both addresses to the AND of the new `taddr` and the stepped `vaddr`. Their other bits take the new `taddr`.
- R14: A second address write on a dot without a step, including the reload dot 257 or a dot outside rendering, copies the new `taddr` into both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor write strobe, one cycle |
| cpu_rd | input | 1 | Processor read strobe, one cycle |
| cpu_sel | input | 2 | Register select: 0 scroll, 1 address, 2 status, 3 data |
| cpu_wdata | input | 8 | Processor write data |
| inc_row | input | 1 | Data-port step of 32 instead of 1 |
| dot | input | 9 | Current dot in the line |
| line | input | 9 | Current scanline, 261 is pre-render |
| bg_en | input | 1 | Background display enabled |
| spr_en | input | 1 | Sprite display enabled |
| vaddr | output | 15 | Current video address |
| taddr | output | 15 | Temporary video address |
| fine_x | output | 3 | Fine horizontal scroll |
| write_toggle | output | 1 | Shared first/second write toggle |

## Verification
The assertions check on every cycle the toggle rules and the fact that `vaddr` equals `taddr` after any second address write. They also check that the low byte of the result stays within the written byte, that `taddr` and `fine_x` hold without scroll or address writes, and that `vaddr` holds when the display is off and the processor is idle. The stepping schedule, the field wraps, the reload dots, the rendering window and the exact values produced by the conflicts depend on dot and line timing. Only the bench's directed scenarios show these, with expected addresses worked out by hand.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;
  localparam int ROW_STEP = 32;

  typedef logic [ADDR_W-1:0] vaddr_t;

  typedef enum logic [1:0] {
    SEL_SCROLL = 2'd0,
    SEL_ADDR   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_DATA   = 2'd3
  } reg_sel_e;

  // coarse X, horizontal table bit
  localparam vaddr_t HORI_MASK = 15'h041F;
  // fine Y, vertical table bit, coarse Y
  localparam vaddr_t VERT_MASK = 15'h7BE0;

  function automatic vaddr_t step_coarse_x(input vaddr_t a);
    vaddr_t r;
    r = a;
    if (a[4:0] == 5'd31) begin
      r[4:0] = 5'd0;
      r[10]  = ~a[10];
    end else begin
      r[4:0] = a[4:0] + 5'd1;
    end
    return r;
  endfunction

  function automatic vaddr_t step_y(input vaddr_t a);
    vaddr_t r;
    r = a;
    if (a[14:12] != 3'd7) begin
      r[14:12] = a[14:12] + 3'd1;
    end else begin
      r[14:12] = 3'd0;
      if (a[9:5] == 5'd29) begin
        r[9:5] = 5'd0;
        r[11]  = ~a[11];
      end else if (a[9:5] == 5'd31) begin
        r[9:5] = 5'd0;
      end else begin
        r[9:5] = a[9:5] + 5'd1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/scroll_render_timing.sv
module scroll_render_timing
  import scroll_pkg::*;
#(
  parameter int DOT_W         = 9,
  parameter int LINE_W        = 9,
  parameter int LAST_VIS_LINE = 239,
  parameter int PRE_LINE      = 261,
  parameter int TILE_LOG2     = 3,
  parameter int STEP_FIRST    = 8,
  parameter int STEP_LAST     = 256,
  parameter int PREFETCH_A    = 328,
  parameter int PREFETCH_B    = 336,
  parameter int HRELOAD_DOT   = 257,
  parameter int VRELOAD_FIRST = 280,
  parameter int VRELOAD_LAST  = 304
) (
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              bg_en,
  input  logic              spr_en,
  output logic              render_on,
  output logic              do_step_x,
  output logic              do_step_y,
  output logic              do_hreload,
  output logic              do_vreload
);
  logic line_in_frame;
  logic is_pre_line;
  logic tile_edge;
  logic in_visible_span;
  logic is_prefetch;

  always_comb begin
    is_pre_line     = (line == LINE_W'(PRE_LINE));
    line_in_frame   = (line <= LINE_W'(LAST_VIS_LINE)) || is_pre_line;
    render_on       = (bg_en || spr_en) && line_in_frame;
    tile_edge       = (dot[TILE_LOG2-1:0] == '0);
    in_visible_span = (dot >= DOT_W'(STEP_FIRST)) && (dot <= DOT_W'(STEP_LAST));
    is_prefetch     = (dot == DOT_W'(PREFETCH_A)) || (dot == DOT_W'(PREFETCH_B));
    do_step_x       = render_on && tile_edge && (in_visible_span || is_prefetch);
    do_step_y       = render_on && (dot == DOT_W'(STEP_LAST));
    do_hreload      = render_on && (dot == DOT_W'(HRELOAD_DOT));
    do_vreload      = render_on && is_pre_line &&
                      (dot >= DOT_W'(VRELOAD_FIRST)) && (dot <= DOT_W'(VRELOAD_LAST));
  end
endmodule

// File: rtl/scroll_cpu_port.sv
module scroll_cpu_port
  import scroll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  vaddr_t            t_q,
  output vaddr_t            t_wr,
  output logic              t_wr_en,
  output logic              copy_stb,
  output logic              data_stb,
  output logic              toggle_q,
  output logic [2:0]        fine_q
);
  reg_sel_e   sel;
  logic       scroll_wr;
  logic       addr_wr;
  logic       status_rd;
  logic       toggle_d;
  logic       toggle_en;
  logic [2:0] fine_d;
  logic       fine_en;

  always_comb begin
    sel       = reg_sel_e'(cpu_sel);
    scroll_wr = cpu_wr && (sel == SEL_SCROLL);
    addr_wr   = cpu_wr && (sel == SEL_ADDR);
    status_rd = cpu_rd && (sel == SEL_STATUS);
    data_stb  = (cpu_wr || cpu_rd) && (sel == SEL_DATA);
    t_wr_en   = scroll_wr || addr_wr;
    copy_stb  = addr_wr && toggle_q;

    t_wr = t_q;
    if (scroll_wr && !toggle_q) begin
      t_wr[4:0] = cpu_wdata[7:3];
    end else if (scroll_wr) begin
      t_wr[14:12] = cpu_wdata[2:0];
      t_wr[9:5]   = cpu_wdata[7:3];
    end else if (addr_wr && !toggle_q) begin
      t_wr[13:8] = cpu_wdata[5:0];
      t_wr[14]   = 1'b0;
    end else if (addr_wr) begin
      t_wr[7:0] = cpu_wdata;
    end

    toggle_en = status_rd || t_wr_en;
    toggle_d  = status_rd ? 1'b0 : ~toggle_q;
    fine_en   = scroll_wr && !toggle_q;
    fine_d    = cpu_wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggle_q <= 1'b0;
      fine_q   <= 3'd0;
    end else begin
      if (toggle_en) toggle_q <= toggle_d;
      if (fine_en)   fine_q   <= fine_d;
    end
  end
endmodule

// File: rtl/scroll_v_update.sv
module scroll_v_update
  import scroll_pkg::*;
(
  input  vaddr_t v_q,
  input  vaddr_t t_q,
  input  logic   render_on,
  input  logic   do_step_x,
  input  logic   do_step_y,
  input  logic   do_hreload,
  input  logic   do_vreload,
  input  logic   data_stb,
  input  logic   inc_row,
  output vaddr_t v_render,
  output vaddr_t v_step
);
  vaddr_t after_x;
  vaddr_t after_y;

  always_comb begin
    after_x  = do_step_x ? step_coarse_x(v_q) : v_q;
    after_y  = do_step_y ? step_y(after_x) : after_x;
    v_render = after_y;
    if (do_hreload) v_render = (v_render & ~HORI_MASK) | (t_q & HORI_MASK);
    if (do_vreload) v_render = (v_render & ~VERT_MASK) | (t_q & VERT_MASK);

    if (!data_stb) begin
      v_step = v_render;
    end else if (render_on) begin
      v_step = step_y(step_coarse_x(v_render));
    end else begin
      v_step = v_render + (inc_row ? vaddr_t'(ROW_STEP) : vaddr_t'(1));
    end
  end
endmodule

// File: rtl/scroll_addr_pair.sv
module scroll_addr_pair
  import scroll_pkg::*;
#(
  parameter int DOT_W         = 9,
  parameter int LINE_W        = 9,
  parameter int LAST_VIS_LINE = 239,
  parameter int PRE_LINE      = 261,
  parameter int RST_STAGES    = 2   // at least 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_sel,
  input  logic [7:0]        cpu_wdata,
  input  logic              inc_row,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              bg_en,
  input  logic              spr_en,
  output logic [14:0]       vaddr,
  output logic [14:0]       taddr,
  output logic [2:0]        fine_x,
  output logic              write_toggle
);
  // reset: asserted at once, released on a clock edge
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  vaddr_t v_q, v_d, t_q, t_d;
  logic   v_en, t_en;

  logic   render_on, do_step_x, do_step_y, do_hreload, do_vreload;
  vaddr_t t_wr, v_render, v_step, merged;
  logic   t_wr_en, copy_stb, data_stb;
  logic   conflict_all, conflict_hori;

  scroll_render_timing #(
    .DOT_W(DOT_W), .LINE_W(LINE_W),
    .LAST_VIS_LINE(LAST_VIS_LINE), .PRE_LINE(PRE_LINE)
  ) i_timing (
    .dot(dot), .line(line), .bg_en(bg_en), .spr_en(spr_en),
    .render_on(render_on), .do_step_x(do_step_x), .do_step_y(do_step_y),
    .do_hreload(do_hreload), .do_vreload(do_vreload)
  );

  scroll_cpu_port i_port (
    .clk(clk), .rst_n(rst_sync_n),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .t_q(t_q), .t_wr(t_wr), .t_wr_en(t_wr_en),
    .copy_stb(copy_stb), .data_stb(data_stb),
    .toggle_q(write_toggle), .fine_q(fine_x)
  );

  scroll_v_update i_vupd (
    .v_q(v_q), .t_q(t_q), .render_on(render_on),
    .do_step_x(do_step_x), .do_step_y(do_step_y),
    .do_hreload(do_hreload), .do_vreload(do_vreload),
    .data_stb(data_stb), .inc_row(inc_row),
    .v_render(v_render), .v_step(v_step)
  );

  // next state
  always_comb begin
    conflict_all  = copy_stb && do_step_y;
    conflict_hori = copy_stb && do_step_x && !do_step_y;

    if (conflict_all) begin
      merged = t_wr & v_render;
    end else if (conflict_hori) begin
      merged = (t_wr & ~HORI_MASK) | (t_wr & v_render & HORI_MASK);
    end else begin
      merged = t_wr;
    end

    if (copy_stb) begin
      v_d = merged;
      t_d = merged;
    end else begin
      v_d = v_step;
      t_d = t_wr;
    end

    v_en = copy_stb || data_stb || do_step_x || do_step_y || do_hreload || do_vreload;
    t_en = t_wr_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v_q <= '0;
      t_q <= '0;
    end else begin
      if (v_en) v_q <= v_d;
      if (t_en) t_q <= t_d;
    end
  end

  assign vaddr = v_q;
  assign taddr = t_q;
endmodule

// File: rtl/scroll_addr_pair_chk.sv
module scroll_addr_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_wr,
  input logic        cpu_rd,
  input logic [1:0]  cpu_sel,
  input logic [7:0]  cpu_wdata,
  input logic        bg_en,
  input logic        spr_en,
  input logic [14:0] vaddr,
  input logic [14:0] taddr,
  input logic [2:0]  fine_x,
  input logic        write_toggle
);
  a_r4_status_clears_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && cpu_sel == 2'd2) |=> !write_toggle);

  a_r2_toggle_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_rd && (cpu_sel == 2'd0 || cpu_sel == 2'd1))
      |=> (write_toggle != $past(write_toggle)));

  a_r3_second_write_aligns: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel == 2'd1 && write_toggle) |=> (vaddr == taddr));

  a_r12_low_byte_within_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel == 2'd1 && write_toggle)
      |=> ((vaddr[7:0] & ~$past(cpu_wdata)) == 8'd0));

  a_r2_fine_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_sel == 2'd0) |=> $stable(fine_x));

  a_r3_temp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && (cpu_sel == 2'd0 || cpu_sel == 2'd1)) |=> $stable(taddr));

  a_r11_idle_display_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!bg_en && !spr_en && !cpu_wr && !cpu_rd) |=> $stable(vaddr));
endmodule

bind scroll_addr_pair scroll_addr_pair_chk i_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
  .bg_en(bg_en), .spr_en(spr_en),
  .vaddr(vaddr), .taddr(taddr), .fine_x(fine_x), .write_toggle(write_toggle)
);

// File: tb/test_scroll_addr_pair.sv
module test_scroll_addr_pair;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr, cpu_rd, inc_row, bg_en, spr_en;
  logic [1:0]  cpu_sel;
  logic [7:0]  cpu_wdata;
  logic [8:0]  dot, line;
  logic [14:0] vaddr, taddr;
  logic [2:0]  fine_x;
  logic        write_toggle;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  scroll_addr_pair i_scroll_addr_pair (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .inc_row(inc_row),
    .dot(dot), .line(line), .bg_en(bg_en), .spr_en(spr_en),
    .vaddr(vaddr), .taddr(taddr), .fine_x(fine_x), .write_toggle(write_toggle)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [1:0]  sel;
    logic [7:0]  d;
    logic        inc;
    logic [14:0] ev;
    logic [14:0] et;
    logic [2:0]  ef;
    logic        eg;
  } vec_t;

  localparam int NV = 16;
  // register-level sequence on a non-rendering line (R2 R3 R4 R5)
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd0, 8'hAB, 1'b0, 15'h0000, 15'h0015, 3'd3, 1'b1},
    '{1'b1, 1'b0, 2'd0, 8'h5E, 1'b0, 15'h0000, 15'h6175, 3'd3, 1'b0},
    '{1'b1, 1'b0, 2'd1, 8'hFF, 1'b0, 15'h0000, 15'h3F75, 3'd3, 1'b1},
    '{1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 15'h0000, 15'h3F75, 3'd3, 1'b0},
    '{1'b1, 1'b0, 2'd1, 8'h21, 1'b0, 15'h0000, 15'h2175, 3'd3, 1'b1},
    '{1'b1, 1'b0, 2'd1, 8'h08, 1'b0, 15'h2108, 15'h2108, 3'd3, 1'b0},
    '{1'b0, 1'b1, 2'd3, 8'h00, 1'b0, 15'h2109, 15'h2108, 3'd3, 1'b0},
    '{1'b1, 1'b0, 2'd3, 8'h00, 1'b1, 15'h2129, 15'h2108, 3'd3, 1'b0},
    '{1'b1, 1'b0, 2'd1, 8'h3F, 1'b0, 15'h2129, 15'h3F08, 3'd3, 1'b1},
    '{1'b1, 1'b0, 2'd1, 8'hFF, 1'b0, 15'h3FFF, 15'h3FFF, 3'd3, 1'b0},
    '{1'b1, 1'b0, 2'd3, 8'h00, 1'b1, 15'h401F, 15'h3FFF, 3'd3, 1'b0},
    '{1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 15'h401F, 15'h3FE0, 3'd0, 1'b1},
    '{1'b1, 1'b0, 2'd0, 8'hFF, 1'b0, 15'h401F, 15'h7FE0, 3'd0, 1'b0},
    '{1'b1, 1'b0, 2'd1, 8'h00, 1'b0, 15'h401F, 15'h00E0, 3'd0, 1'b1},
    '{1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 15'h401F, 15'h0000, 3'd0, 1'b0},
    '{1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 15'h401F, 15'h0000, 3'd0, 1'b0}
  };

  task automatic chk(input string tag, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one dot from a falling edge; outputs are sampled at the next falling edge
  task automatic cyc(input logic wr, input logic rd, input logic [1:0] sel,
                     input logic [7:0] d, input logic inc, input int dt, input int ln,
                     input logic bg, input logic spr);
    cpu_wr = wr; cpu_rd = rd; cpu_sel = sel; cpu_wdata = d; inc_row = inc;
    dot = 9'(dt); line = 9'(ln); bg_en = bg; spr_en = spr;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic set_addr(input logic [14:0] a);
    cyc(1'b1, 1'b0, 2'd1, {1'b0, a[14:8]}, 1'b0, 0, 240, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 2'd1, a[7:0],          1'b0, 0, 240, 1'b1, 1'b0);
  endtask

  task automatic render(input int dt, input int ln);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, dt, ln, 1'b1, 1'b0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_sel = 2'd0; cpu_wdata = 8'h00; inc_row = 1'b0;
    dot = '0; line = 9'd240; bg_en = 1'b0; spr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 vaddr", vaddr, 15'h0000);
    chk("R1 taddr", taddr, 15'h0000);
    chk("R1 fine_x", {12'd0, fine_x}, 15'd0);
    chk("R1 toggle", {14'd0, write_toggle}, 15'd0);

    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].wr, VECS[i].rd, VECS[i].sel, VECS[i].d, VECS[i].inc, 0, 240, 1'b1, 1'b0);
      chk($sformatf("R2 R3 R4 R5 vec %0d vaddr", i), vaddr, VECS[i].ev);
      chk($sformatf("R2 R3 R4 R5 vec %0d taddr", i), taddr, VECS[i].et);
      chk($sformatf("R2 vec %0d fine_x", i), {12'd0, fine_x}, {12'd0, VECS[i].ef});
      chk($sformatf("R3 R4 vec %0d toggle", i), {14'd0, write_toggle}, {14'd0, VECS[i].eg});
    end

    // R7 coarse X schedule and wrap, R11 rendering window
    set_addr(15'h001F);
    render(8, 10);   chk("R7 wrap into bit 10", vaddr, 15'h0400);
    render(9, 10);   chk("R7 no step off tile edge", vaddr, 15'h0400);
    render(16, 10);  chk("R7 step at dot 16", vaddr, 15'h0401);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 24, 10, 1'b0, 1'b0);
    chk("R11 display off no step", vaddr, 15'h0401);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 24, 100, 1'b0, 1'b1);
    chk("R11 sprite enable alone steps", vaddr, 15'h0402);
    render(32, 240); chk("R11 line 240 no step", vaddr, 15'h0402);
    render(40, 261); chk("R11 pre-render line steps", vaddr, 15'h0403);
    render(0, 10);   chk("R7 dot 0 no step", vaddr, 15'h0403);
    render(328, 10); chk("R7 prefetch dot 328", vaddr, 15'h0404);
    chk("R7 taddr untouched", taddr, 15'h001F);

    // R8 Y step, coarse Y 29 wraps and flips bit 11
    set_addr(15'h33A0);
    render(256, 10); chk("R8 fine Y step", vaddr, 15'h43A1);
    for (int k = 0; k < 4; k++) render(256, 10);
    chk("R8 coarse Y 29 wrap", vaddr, 15'h0805);
    // coarse Y 31 wraps without flip
    set_addr(15'h33E0);
    for (int k = 0; k < 5; k++) render(256, 10);
    chk("R8 coarse Y 31 wrap", vaddr, 15'h0005);

    // R9 horizontal reload
    set_addr(15'h041F);
    render(8, 5);    chk("R9 setup step", vaddr, 15'h0000);
    render(257, 5);  chk("R9 horizontal reload", vaddr, 15'h041F);

    // R10 vertical reload only on pre-render line
    set_addr(15'h2BC0);
    render(256, 5);  chk("R10 setup Y step", vaddr, 15'h3BC1);
    render(280, 5);  chk("R10 no reload on line 5", vaddr, 15'h3BC1);
    render(280, 261); chk("R10 vertical reload", vaddr, 15'h2BC1);

    // R6 data access during rendering
    cyc(1'b0, 1'b1, 2'd3, 8'h00, 1'b1, 3, 5, 1'b1, 1'b0);
    chk("R6 data access steps X and Y", vaddr, 15'h3BC2);
    chk("R6 taddr untouched", taddr, 15'h2BC0);

    // R12 full conflict at dot 256
    cyc(1'b1, 1'b0, 2'd1, 8'h12, 1'b0, 1, 5, 1'b1, 1'b0);
    chk("R12 first write", taddr, 15'h12C0);
    cyc(1'b1, 1'b0, 2'd1, 8'h34, 1'b0, 256, 5, 1'b1, 1'b0);
    chk("R12 vaddr", vaddr, 15'h0200);
    chk("R12 taddr", taddr, 15'h0200);

    // R13 horizontal conflict at dot 40
    set_addr(15'h156A);
    cyc(1'b1, 1'b0, 2'd1, 8'h27, 1'b0, 1, 5, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 2'd1, 8'h5B, 1'b0, 40, 5, 1'b1, 1'b0);
    chk("R13 vaddr", vaddr, 15'h274B);
    chk("R13 taddr", taddr, 15'h274B);

    // R14 plain copy: display off at a step dot, and on the reload dot
    cyc(1'b1, 1'b0, 2'd1, 8'h11, 1'b0, 40, 5, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 2'd1, 8'h22, 1'b0, 40, 5, 1'b0, 1'b0);
    chk("R14 display off copy", vaddr, 15'h1122);
    cyc(1'b1, 1'b0, 2'd1, 8'h0A, 1'b0, 0, 240, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 2'd1, 8'h55, 1'b0, 257, 5, 1'b1, 1'b0);
    chk("R14 copy wins over reload", vaddr, 15'h0A55);
    chk("R14 taddr", taddr, 15'h0A55);

    summary();
    $finish;
  end
endmodule